// File: doc/BRIEF.md
# Key-Protected Memory Configuration Register

This block is a small register-bus peripheral. It holds the 3-bit code that selects how much internal RAM the chip uses, and it keeps that code locked behind an unlock key register. Software first writes the unlock key (0x96) into the key register. It then writes the new size code, and afterwards writes any other value into the key register to lock the field again. While the key register holds any value other than 0x96, writes to the size code have no effect. The lock stays open for as long as the key register keeps the unlock value.

The block decodes the stored code into a RAM size in bytes and raises a flag when the code is one of the reserved values. It also provides a read-only 32-bit register that gives the base address of the 64-byte debug work area. The bus has one cycle per access: a write strobe commits on the rising clock edge, and the read data follows the address combinationally.

Top module: `memcfg_regblk`

## Requirements
- R1: After reset the key register reads 0x00, the size code reads 3 and the size field is locked.
- R2: A write to the size register (byte offset 0x4) while the key register holds any value other than 0x96 leaves the stored code unchanged.
- R3: A write to the size register while the key register holds 0x96 stores wdata[2:0] on that clock edge. The stored code reads back in bits 2:0 from the next cycle, and bits 31:3 read as zero.
- R4: The key register (byte offset 0x0) stores wdata[7:0] on every write and reads it back in bits 7:0. The unlock stays in force across any number of size writes until a value other than 0x96 is written to the key register. After that, size writes are ignored again.
- R5: The decoded size output reports 512 for code 5, 1024 for code 4 and 2048 for code 3.
- R6: Codes 0, 1, 2, 6 and 7 are reserved. A reserved code is still stored when the field is unlocked, the reserved flag output is 1 and the decoded size output is 0. For codes 3, 4 and 5 the flag is 0.
- R7: The debug base register (byte offset 0x8) always reads 0x000007C0, and writes to it change nothing.
- R8: Reads of any unmapped offset return zero, and writes to such an offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, committed at the rising edge |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cfg_size_code | output | 3 | Stored RAM size code |
| cfg_ram_bytes | output | 12 | Decoded RAM size in bytes, 0 for reserved codes |
| cfg_reserved | output | 1 | High while the stored code is reserved |

## Verification
On every cycle, the assertions check the following:
- The size code holds still whenever the key is not present.
- An unlocked write lands exactly one edge later.
- The key register changes only when it is written.
- The decoded size is either a single power of two or zero with the reserved flag set.
- The base register reads its constant value.

Only the bench scenarios can show the complete unlock, write and relock sequence as software sees it. The same applies to the persistence of the unlock over several writes, the readback layout of each register, and the absence of any effect from writes to the base register and to unmapped offsets.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
    localparam int KEY_W      = 8;
    localparam int SIZE_W     = 3;
    localparam int BYTES_W    = 12;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int BASE_W     = 24;

    localparam logic [KEY_W-1:0]  UNLOCK_KEY = 8'h96;
    localparam logic [KEY_W-1:0]  KEY_RST    = 8'h00;
    localparam logic [SIZE_W-1:0] SIZE_RST   = 3'd3;
    localparam logic [BASE_W-1:0] DBG_BASE   = 24'h0007C0;

    // largest size code maps to the smallest RAM; codes in between halve
    localparam int CODE_BIG   = 3;
    localparam int CODE_SMALL = 5;
    localparam int BIG_LOG2   = BYTES_W - 1;

    localparam logic [ADDR_W-1:0] OFS_KEY  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_BASE = 4'h8;

    typedef struct packed {
        logic [KEY_W-1:0] key;
    } key_state_t;

    typedef struct packed {
        logic [SIZE_W-1:0] code;
    } size_state_t;

    function automatic logic code_is_legal(input logic [SIZE_W-1:0] c);
        return (int'(c) >= CODE_BIG) && (int'(c) <= CODE_SMALL);
    endfunction

    function automatic logic [BYTES_W-1:0] code_to_bytes(input logic [SIZE_W-1:0] c);
        logic [BYTES_W-1:0] b;
        b = '0;
        if (code_is_legal(c)) begin
            b = BYTES_W'(1) << (BIG_LOG2 - (int'(c) - CODE_BIG));
        end
        return b;
    endfunction
endpackage

// File: rtl/memcfg_key_gate.sv
module memcfg_key_gate
    import memcfg_pkg::*;
#(
    parameter int               W   = KEY_W,
    parameter logic [W-1:0]     KEY = UNLOCK_KEY,
    parameter logic [W-1:0]     RST = KEY_RST
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic         sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] key_o,
    output logic         unlocked_o
);
    logic [W-1:0] key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (we_i && sel_i) begin
            key_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= RST;
        else        key_q <= key_d;
    end

    assign key_o      = key_q;
    assign unlocked_o = (key_q == KEY);

    // R4: the key only moves on a write addressed to it
    a_r4_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && sel_i) |=> $stable(key_q));

    // R4: a write to the key lands on the next cycle
    a_r4_key_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i) |=> (key_o == $past(wdata_i)));
endmodule

// File: rtl/memcfg_size_field.sv
module memcfg_size_field
    import memcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic               sel_i,
    input  logic               unlocked_i,
    input  logic [SIZE_W-1:0]  wdata_i,
    output logic [SIZE_W-1:0]  code_o,
    output logic [BYTES_W-1:0] bytes_o,
    output logic               reserved_o
);
    size_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && sel_i && unlocked_i) begin
            st_d.code = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code: SIZE_RST};
        else        st_q <= st_d;
    end

    assign code_o     = st_q.code;
    assign bytes_o    = code_to_bytes(st_q.code);
    assign reserved_o = !code_is_legal(st_q.code);

    // R2: no key, no change
    a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked_i |=> $stable(code_o));

    // R3: an unlocked write is stored on the edge
    a_r3_unlocked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked_i && we_i && sel_i) |=> (code_o == $past(wdata_i)));

    // R5 / R6: decoded size is a single power of two, or zero with the flag up
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reserved_o |-> (bytes_o == '0));
    a_r5_onehot_size: assert property (@(posedge clk) disable iff (!rst_n)
        !reserved_o |-> ($countones(bytes_o) == 1 && bytes_o >= BYTES_W'(512)));
endmodule

// File: rtl/memcfg_rd_mux.sv
module memcfg_rd_mux
    import memcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [SIZE_W-1:0] code_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_KEY:  rdata_o = DATA_W'(key_i);
            OFS_SIZE: rdata_o = DATA_W'(code_i);
            OFS_BASE: rdata_o = DATA_W'(DBG_BASE);
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/memcfg_regblk.sv
module memcfg_regblk
    import memcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [SIZE_W-1:0]  cfg_size_code,
    output logic [BYTES_W-1:0] cfg_ram_bytes,
    output logic               cfg_reserved
);
    logic             sel_key, sel_size;
    logic [KEY_W-1:0] key_val;
    logic             unlocked;
    logic             unused_wdata;

    assign sel_key      = (bus_addr == OFS_KEY);
    assign sel_size     = (bus_addr == OFS_SIZE);
    assign unused_wdata = ^bus_wdata[DATA_W-1:KEY_W];

    memcfg_key_gate u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (bus_we),
        .sel_i      (sel_key),
        .wdata_i    (bus_wdata[KEY_W-1:0]),
        .key_o      (key_val),
        .unlocked_o (unlocked)
    );

    memcfg_size_field u_size (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (bus_we),
        .sel_i      (sel_size),
        .unlocked_i (unlocked),
        .wdata_i    (bus_wdata[SIZE_W-1:0]),
        .code_o     (cfg_size_code),
        .bytes_o    (cfg_ram_bytes),
        .reserved_o (cfg_reserved)
    );

    memcfg_rd_mux u_rd (
        .addr_i  (bus_addr),
        .key_i   (key_val),
        .code_i  (cfg_size_code),
        .rdata_o (bus_rdata)
    );

    // R7: base register is constant on the bus
    a_r7_base_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_BASE) |-> (bus_rdata == 32'h0000_07C0));
endmodule

// File: tb/memcfg_regblk_tb.sv
module memcfg_regblk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cfg_size_code;
    logic [11:0] cfg_ram_bytes;
    logic        cfg_reserved;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_key;
    logic [2:0] m_code;

    always #2 clk = ~clk;

    memcfg_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_size_code(cfg_size_code), .cfg_ram_bytes(cfg_ram_bytes),
        .cfg_reserved(cfg_reserved)
    );

    function automatic logic [11:0] exp_bytes(input logic [2:0] c);
        case (c)
            3'd3: return 12'd2048;
            3'd4: return 12'd1024;
            3'd5: return 12'd512;
            default: return 12'd0;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0: return {24'h0, m_key};
            4'h4: return {29'h0, m_code};
            4'h8: return 32'h0000_07C0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 4'h0) m_key = d[7:0];
        else if (a == 4'h4 && m_key == 8'h96) m_code = d[2:0];
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic out_chk(input string tag);
        check({tag, " code"}, {29'h0, cfg_size_code}, {29'h0, m_code});
        check({tag, " bytes"}, {20'h0, cfg_ram_bytes}, {20'h0, exp_bytes(m_code)});
        check({tag, " rsv"}, {31'h0, cfg_reserved}, {31'h0, exp_bytes(m_code) == 0});
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_key = 8'h00; m_code = 3'd3;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd_chk("R1 key reset", 4'h0);
        rd_chk("R1 size reset", 4'h4);
        out_chk("R1");
        rst_n = 1'b1;
        // R2 locked write ignored
        wr(4'h4, 32'h5);
        rd_chk("R2 locked size", 4'h4);
        out_chk("R2");
        wr(4'h0, 32'h95);
        wr(4'h4, 32'h4);
        rd_chk("R2 near-key size", 4'h4);
        // R3 / R4 unlock, several writes
        wr(4'h0, 32'hFFFF_FF96);
        rd_chk("R4 key read", 4'h0);
        wr(4'h4, 32'hFFFF_FFFD);
        rd_chk("R3 size stored", 4'h4);
        out_chk("R5 code5");
        wr(4'h4, 32'h4);
        out_chk("R5 code4");
        wr(4'h4, 32'h3);
        out_chk("R5 code3");
        // R6 reserved codes stored
        for (int c = 0; c < 8; c++) begin
            wr(4'h4, 32'(c));
            rd_chk("R6 size rd", 4'h4);
            out_chk("R6");
        end
        // R4 relock
        wr(4'h0, 32'h00);
        wr(4'h4, 32'h5);
        rd_chk("R4 relocked", 4'h4);
        out_chk("R4 relocked");
        // R7 base write ignored
        wr(4'h8, 32'hDEAD_BEEF);
        rd_chk("R7 base", 4'h8);
        rd_chk("R7 key after", 4'h0);
        // R8 unmapped
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk("R8 unmapped", 4'hC);
        rd_chk("R8 key after", 4'h0);
        rd_chk("R8 size after", 4'h4);
        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  a;
            logic [31:0] d;
            a = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) a = 4'h0;
            else if ($urandom_range(0, 1) == 0) a = 4'h4;
            d = $urandom;
            if (a == 4'h0 && $urandom_range(0, 1) == 0) d[7:0] = 8'h96;
            wr(a, d);
            rd_chk("R3 rand size", 4'h4);
            rd_chk("R4 rand key", 4'h0);
            rd_chk("R8 rand addr", a);
            out_chk("R6 rand");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule